// File: doc/BRIEF.md
# Input Port Handshake Adapter

This block sits between an outside data producer and a core that consumes one input value at a time. The core raises a read strobe whenever it wants the next value. The adapter decides three things: whether that read completes in the current cycle or the core must stall, whether the producer is told that its word was consumed, and whether the word is captured before the core asks for it. A compile-time mode parameter picks one of four protocol variants. In two-way mode the producer supplies a valid and gets an acknowledge back. In acknowledge-only mode there is no valid and only an acknowledge is returned. In valid-only mode there is a valid but no acknowledge, and a one-word holding buffer is used. In plain mode the data passes straight through with no control signals.

The adapter stays idle until it sees a start pulse. From then on it serves reads in the chosen mode until reset. Back-pressure is expressed only through the stall output. In two-way mode a read with the producer's valid low stalls the core. In valid-only mode a read stalls only when the buffer is empty and valid is low. In the other two modes the core never stalls. The producer has no way to stall the adapter. In valid-only mode a word that arrives while the buffer is full replaces the held word.

Top module: `hsa_port_adapter`

## Requirements
- R1: Before the adapter has started, `prod_ack` and `core_stall` are 0, `core_data` is 0, and valid-only mode captures nothing.
- R2: A cycle with `start` high makes the adapter active from the next clock cycle onward. It stays active until reset.
- R3: Two-way mode, active: `core_stall` is 1 exactly in the cycles where `core_rd` is 1 and `prod_valid` is 0.
- R4: Two-way mode, active: `prod_ack` is 1 in the same cycle where `core_rd` and `prod_valid` are both 1, and `core_data` equals `prod_data`.
- R5: Acknowledge-only mode, active: `prod_ack` is 1 in exactly the cycles where `core_rd` is 1, `core_stall` is always 0, and `core_data` equals `prod_data`.
- R6: Valid-only mode, active: `prod_valid` high with no read loads `prod_data` into the buffer and marks it full at the next edge.
- R7: Valid-only mode: a read while the buffer is full returns the held word. At the next edge the buffer becomes empty, unless `prod_valid` is high in that same cycle, in which case the new word is loaded and the buffer stays full.
- R8: Valid-only mode: a new valid word that arrives while the buffer is full, with no read, overwrites the held word.
- R9: Valid-only mode: a read with the buffer empty and `prod_valid` high takes `prod_data` directly without storing it. A read with the buffer empty and `prod_valid` low stalls.
- R10: Plain mode, active: `core_data` equals `prod_data` and `core_stall` is always 0.
- R11: Synchronous reset (`rst` high at an edge) clears the active state, the buffer-full flag and the held word.
- R12: In valid-only and plain modes, `prod_ack` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse; activates the adapter |
| prod_data | input | DATA_W | Data word from the producer |
| prod_valid | input | 1 | Producer valid (ignored in acknowledge-only and plain modes) |
| prod_ack | output | 1 | Consumed indication back to the producer |
| core_rd | input | 1 | Core read request |
| core_stall | output | 1 | Core must hold its read and retry |
| core_data | output | DATA_W | Word delivered to the core |

## Verification
`prod_ack`, `core_stall` and `core_data` are combinational functions of the present inputs and the registered state, so they are due in the same cycle as the stimulus. The active flag, the buffer-full flag and the held word change only at the following rising edge. The bench applies its inputs just after a falling edge and compares all three outputs of four instances, one per mode, 1 ns later, still before the next rising edge. Its reference model then advances its own state once per cycle, so a captured or drained word first becomes visible in the cycle after the edge that stored it.

// File: rtl/hsa_pkg.sv
package hsa_pkg;
  typedef enum logic [1:0] {
    HSA_TWO_WAY    = 2'd0,
    HSA_ACK_ONLY   = 2'd1,
    HSA_VALID_ONLY = 2'd2,
    HSA_WIRE       = 2'd3
  } hsa_mode_e;
endpackage

// File: rtl/hsa_run_tracker.sv
module hsa_run_tracker (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic run_q
);
  always_ff @(posedge clk) begin
    if (rst)        run_q <= 1'b0;
    else if (start) run_q <= 1'b1;
  end

  // R2: once active, stays active until reset
  p_run_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    run_q |=> run_q);
endmodule

// File: rtl/hsa_vld_buffer.sv
module hsa_vld_buffer #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              rd,
  output logic              full_q,
  output logic [DATA_W-1:0] out_data,
  output logic              stall
);
  logic [DATA_W-1:0] hold_q;
  logic take_direct, capture, drain;

  always_comb begin
    take_direct = run & rd & ~full_q & in_valid;
    capture     = run & in_valid & ~take_direct;
    drain       = run & rd & full_q;
    out_data    = full_q ? hold_q : in_data;
    stall       = run & rd & ~full_q & ~in_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      full_q <= 1'b0;
    end else if (capture) begin
      hold_q <= in_data;
      full_q <= 1'b1;
    end else if (drain) begin
      full_q <= 1'b0;
    end
  end

  // R6: valid without read stores the word
  p_capture_r6: assert property (@(posedge clk) disable iff (rst)
    (run && in_valid && !rd) |=> (full_q && hold_q == $past(in_data)));
  // R7: read of a full buffer with no new word empties it
  p_drain_r7: assert property (@(posedge clk) disable iff (rst)
    (run && rd && full_q && !in_valid) |=> !full_q);
  // R8: new word while full replaces the held one
  p_overwrite_r8: assert property (@(posedge clk) disable iff (rst)
    (run && full_q && in_valid) |=> (full_q && hold_q == $past(in_data)));
  // R1: nothing is captured while idle
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!run && !full_q) |=> !full_q);
endmodule

// File: rtl/hsa_port_adapter.sv
module hsa_port_adapter
  import hsa_pkg::*;
#(
  parameter hsa_mode_e MODE   = HSA_TWO_WAY,
  parameter int        DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] prod_data,
  input  logic              prod_valid,
  output logic              prod_ack,
  input  logic              core_rd,
  output logic              core_stall,
  output logic [DATA_W-1:0] core_data
);
  logic              run;
  logic [DATA_W-1:0] sel_data;
  logic              ack_c;
  logic              stall_c;
  logic              unused_valid;

  assign unused_valid = prod_valid;

  hsa_run_tracker u_run (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .run_q (run)
  );

  generate
    if (MODE == HSA_TWO_WAY) begin : g_two_way
      always_comb begin
        sel_data = prod_data;
        ack_c    = run & core_rd & prod_valid;
        stall_c  = run & core_rd & ~prod_valid;
      end
      // R3: stall only on a read lacking valid
      p_stall_cause_r3: assert property (@(posedge clk) disable iff (rst)
        core_stall |-> (core_rd && !prod_valid));
      // R4: acknowledge marks a completed read
      p_ack_cause_r4: assert property (@(posedge clk) disable iff (rst)
        prod_ack |-> (core_rd && prod_valid && !core_stall));
    end else if (MODE == HSA_ACK_ONLY) begin : g_ack_only
      always_comb begin
        sel_data = prod_data;
        ack_c    = run & core_rd;
        stall_c  = 1'b0;
      end
      // R5: acknowledge only for a read
      p_ack_read_r5: assert property (@(posedge clk) disable iff (rst)
        prod_ack |-> (core_rd && !core_stall));
    end else if (MODE == HSA_VALID_ONLY) begin : g_valid_only
      logic              buf_full;
      logic [DATA_W-1:0] buf_data;
      logic              buf_stall;
      hsa_vld_buffer #(.DATA_W(DATA_W)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .in_data  (prod_data),
        .in_valid (prod_valid),
        .rd       (core_rd),
        .full_q   (buf_full),
        .out_data (buf_data),
        .stall    (buf_stall)
      );
      always_comb begin
        sel_data = buf_data;
        ack_c    = 1'b0;
        stall_c  = buf_stall;
      end
      // R9: no stall while a word is held or arriving
      p_stall_empty_r9: assert property (@(posedge clk) disable iff (rst)
        core_stall |-> (core_rd && !prod_valid && !buf_full));
    end else begin : g_wire
      always_comb begin
        sel_data = prod_data;
        ack_c    = 1'b0;
        stall_c  = 1'b0;
      end
    end
  endgenerate

  assign prod_ack   = ack_c;
  assign core_stall = stall_c;
  assign core_data  = run ? sel_data : '0;

  // R1: idle adapter signals nothing
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !run |-> (!prod_ack && !core_stall && core_data == '0));
  // R2: start takes effect at the next edge
  p_start_arms_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> run);
endmodule

// File: tb/hsa_port_adapter_tb_top.sv
module hsa_port_adapter_tb_top;
  import hsa_pkg::*;

  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic core_rd = 1'b0;
  logic prod_valid = 1'b0;
  logic [W-1:0] prod_data = '0;

  logic a_hs, a_ak, a_vl, a_wr;
  logic s_hs, s_ak, s_vl, s_wr;
  logic [W-1:0] d_hs, d_ak, d_vl, d_wr;

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  bit m_run = 0;
  bit m_full = 0;
  logic [W-1:0] m_hold = '0;

  always #2 clk = ~clk;

  hsa_port_adapter #(.MODE(HSA_TWO_WAY), .DATA_W(W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .prod_data(prod_data), .prod_valid(prod_valid),
    .prod_ack(a_hs), .core_rd(core_rd), .core_stall(s_hs), .core_data(d_hs));
  hsa_port_adapter #(.MODE(HSA_ACK_ONLY), .DATA_W(W)) dut_ack (
    .clk(clk), .rst(rst), .start(start), .prod_data(prod_data), .prod_valid(prod_valid),
    .prod_ack(a_ak), .core_rd(core_rd), .core_stall(s_ak), .core_data(d_ak));
  hsa_port_adapter #(.MODE(HSA_VALID_ONLY), .DATA_W(W)) dut_vld (
    .clk(clk), .rst(rst), .start(start), .prod_data(prod_data), .prod_valid(prod_valid),
    .prod_ack(a_vl), .core_rd(core_rd), .core_stall(s_vl), .core_data(d_vl));
  hsa_port_adapter #(.MODE(HSA_WIRE), .DATA_W(W)) dut_wire (
    .clk(clk), .rst(rst), .start(start), .prod_data(prod_data), .prod_valid(prod_valid),
    .prod_ack(a_wr), .core_rd(core_rd), .core_stall(s_wr), .core_data(d_wr));

  task automatic chk(input string tag, input string ph, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s]: actual %h expected %h", tag, ph, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic s, input logic rd, input logic v,
                      input logic [W-1:0] d, input string ph);
    logic [W-1:0] e_vd;
    logic e_vs;
    @(negedge clk);
    rst = r; start = s; core_rd = rd; prod_valid = v; prod_data = d;
    #1;
    // two-way mode
    chk(m_run ? "R4 ack" : "R1 ack", ph, {15'b0, a_hs}, {15'b0, m_run & rd & v});
    chk(m_run ? "R3 stall" : "R1 stall", ph, {15'b0, s_hs}, {15'b0, m_run & rd & ~v});
    chk(m_run ? "R4 data" : "R1 data", ph, d_hs, m_run ? d : '0);
    // acknowledge-only mode
    chk(m_run ? "R5 ack" : "R1 ack", ph, {15'b0, a_ak}, {15'b0, m_run & rd});
    chk(m_run ? "R5 stall" : "R1 stall", ph, {15'b0, s_ak}, 16'd0);
    chk(m_run ? "R5 data" : "R1 data", ph, d_ak, m_run ? d : '0);
    // valid-only mode
    e_vs = m_run & rd & ~m_full & ~v;
    e_vd = m_run ? (m_full ? m_hold : d) : '0;
    chk("R12 ack", ph, {15'b0, a_vl}, 16'd0);
    chk(m_run ? "R9 stall" : "R1 stall", ph, {15'b0, s_vl}, {15'b0, e_vs});
    chk(m_run ? (m_full ? "R7 data" : "R9 data") : "R1 data", ph, d_vl, e_vd);
    // plain mode
    chk("R12 ack", ph, {15'b0, a_wr}, 16'd0);
    chk(m_run ? "R10 stall" : "R1 stall", ph, {15'b0, s_wr}, 16'd0);
    chk(m_run ? "R10 data" : "R1 data", ph, d_wr, m_run ? d : '0);
    // model advance for the coming edge
    if (r) begin
      m_run = 0; m_full = 0; m_hold = '0;
    end else begin
      if (m_run && v && !(rd && !m_full)) begin
        m_hold = d; m_full = 1;
      end else if (m_run && rd && m_full) begin
        m_full = 0;
      end
      if (s) m_run = 1;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    step(1, 0, 0, 0, 16'h0000, "R11 reset");
    step(1, 0, 1, 1, 16'h1111, "R11 reset");
    step(0, 0, 1, 1, 16'h2222, "R1 idle");
    step(0, 0, 0, 1, 16'h3333, "R1 idle no capture");
    step(0, 0, 1, 0, 16'h4444, "R1 idle");
    step(0, 1, 1, 1, 16'h5555, "R2 start cycle");
    step(0, 0, 1, 0, 16'h6666, "R2 R3 first active read");
    step(0, 0, 1, 1, 16'h7777, "R4 read with valid");
    step(0, 0, 0, 0, 16'h8888, "R5 no read");
    step(0, 0, 0, 1, 16'hA001, "R6 capture");
    step(0, 0, 1, 0, 16'hA002, "R7 read held");
    step(0, 0, 1, 0, 16'hA003, "R9 empty stall");
    step(0, 0, 0, 1, 16'hB001, "R8 first word");
    step(0, 0, 0, 1, 16'hB002, "R8 overwrite");
    step(0, 0, 1, 1, 16'hB003, "R7 read and reload");
    step(0, 0, 1, 0, 16'hB004, "R7 read reloaded");
    step(0, 0, 1, 1, 16'hC001, "R9 direct take");
    step(0, 0, 0, 0, 16'hC002, "R9 nothing stored");
    step(0, 0, 0, 1, 16'hD001, "R11 fill before reset");
    step(1, 0, 0, 0, 16'hD002, "R11 mid reset");
    step(0, 0, 1, 0, 16'hD003, "R11 idle after reset");
    step(0, 1, 0, 0, 16'hD004, "R2 restart");
    step(0, 0, 1, 0, 16'hD005, "R11 buffer empty after reset");
    for (int i = 0; i < 300; i++) begin
      step(($urandom % 40) == 0, ($urandom % 8) == 0, $urandom % 2, $urandom % 2,
           16'($urandom), "R10 R12 mixed");
    end
    summary();
    $finish;
  end
endmodule